// File: doc/BRIEF.md
# Memory Device Boundary-Scan Test Port Controller

This block is the serial test port of a memory device. Four scan pins (test clock, mode select, serial data in, serial data out) and an optional asynchronous reset drive the standard sixteen-state test-port state machine. The machine loads a 3-bit instruction and places one data register between the serial input and the serial output. That register is a fixed 32-bit identification word, a single-bit bypass stage, or the device's external boundary chain.

The boundary cells, the memory array and the pads sit outside the block. It hands them a chain-select level and capture, shift and update strobes, and reads the chain's serial output back. The opcode map departs from the usual one. Besides the usual sample-and-preload, it has a separate sample instruction that also forces every bidirectional data output of the device to high impedance while the pins are sampled. The block provides that override as a dedicated output-disable level.

Top module: `mem_tap`

## Requirements
- R1: Holding the mode-select input high for five test-clock rising edges, from any state, reaches Test-Logic-Reset. The active instruction then becomes the identification opcode 001, and the output-disable level goes low.
- R2: Driving the asynchronous reset `trst_n` low sets the same reset conditions at once, with no clock edge needed: identification instruction active, `out_hiz` low, `tdo_en` low.
- R3: In Capture-IR the instruction shift stage loads 001. Shifting then returns it least significant bit first, so the first three TDO bits read are 1, 0, 0.
- R4: With the identification instruction active, a data scan returns the 32-bit word {3'b000, 17'b01011001000100101, 11'b00000110100, 1'b1} least significant bit first.
- R5: Opcodes 000 (external test), 010 (sample with outputs disabled) and 100 (sample/preload) raise `bnd_sel`. During Shift-DR, TDO then carries `bnd_tdo`.
- R6: Opcode 111 and the unassigned opcodes 011, 101 and 110 select the one-bit bypass stage. It captures 0 in Capture-DR, so in Shift-DR the first TDO bit is 0 and every later bit is the TDI bit shifted in one clock earlier.
- R7: `out_hiz` is high exactly while opcode 010 is the active instruction.
- R8: A shifted-in opcode takes effect only on the falling test-clock edge in Update-IR. In Exit1-IR the outputs still reflect the previous instruction.
- R9: TDO and `tdo_en` change on falling test-clock edges. `tdo_en` is high only in Shift-IR and Shift-DR.
- R10: `bnd_capture`, `bnd_shift` and `bnd_update` are each high only in Capture-DR, Shift-DR and Update-DR respectively, and only while `bnd_sel` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| trst_n | input | 1 | Asynchronous test reset, active low |
| bnd_tdo | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_en | output | 1 | Output enable for the TDO pad |
| bnd_sel | output | 1 | Boundary chain is the selected data register |
| bnd_capture | output | 1 | Boundary capture strobe (Capture-DR) |
| bnd_shift | output | 1 | Boundary shift strobe (Shift-DR) |
| bnd_update | output | 1 | Boundary update strobe (Update-DR) |
| out_hiz | output | 1 | Forces the device's bidirectional data outputs to high impedance |

## Verification
The bench loads all eight 3-bit opcodes in turn. After each load it runs a data scan with the non-uniform pattern 0101_0110 while the boundary chain's serial output is held at 1. That one scan separates the three possible paths: the boundary chain gives all ones, the bypass stage gives a leading 0 followed by the delayed pattern, and the identification register gives the low byte of its word. The opcode order toggles the output-disable level in both directions, so an instruction that takes effect before Update-IR shows up in Exit1-IR. Reset is tried twice with sample-with-outputs-disabled active, once through five mode-select-high clocks and once through the asynchronous reset pin, and each time the full identification word is read back.

// File: rtl/mem_tap.sv
`timescale 1ns/1ps
module mem_tap #(
  parameter int          IR_W     = 3,
  parameter int          ID_W     = 32,
  parameter logic [31:0] ID_VALUE = {3'b000, 17'b01011001000100101, 11'b00000110100, 1'b1}
) (
  input  logic tck,
  input  logic tms,
  input  logic tdi,
  input  logic trst_n,
  input  logic bnd_tdo,
  output logic tdo,
  output logic tdo_en,
  output logic bnd_sel,
  output logic bnd_capture,
  output logic bnd_shift,
  output logic bnd_update,
  output logic out_hiz
);
  localparam logic [IR_W-1:0] OP_EXTEST  = IR_W'(0);
  localparam logic [IR_W-1:0] OP_IDCODE  = IR_W'(1);
  localparam logic [IR_W-1:0] OP_SAMPLEZ = IR_W'(2);
  localparam logic [IR_W-1:0] OP_PRELOAD = IR_W'(4);

  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_state_e;

  tap_state_e state, nxt;
  logic [IR_W-1:0] ir_sh, ir;
  logic [ID_W-1:0] id_sh;
  logic            byp;
  logic            id_sel, dr_bit;

  always_comb begin
    unique case (state)
      S_TLR:    nxt = tms ? S_TLR    : S_RTI;
      S_RTI:    nxt = tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: nxt = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: nxt = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  nxt = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: nxt = tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: nxt = tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: nxt = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: nxt = tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: nxt = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: nxt = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  nxt = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: nxt = tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: nxt = tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: nxt = tms ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: nxt = tms ? S_SEL_DR : S_RTI;
      default:  nxt = S_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) state <= S_TLR;
    else         state <= nxt;

  always_ff @(posedge tck) begin
    if (state == S_CAP_IR)     ir_sh <= OP_IDCODE;
    else if (state == S_SH_IR) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
  end

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n)                ir <= OP_IDCODE;
    else if (state == S_TLR)    ir <= OP_IDCODE;
    else if (state == S_UPD_IR) ir <= ir_sh;

  assign id_sel  = (ir == OP_IDCODE);
  assign bnd_sel = (ir == OP_EXTEST) || (ir == OP_SAMPLEZ) || (ir == OP_PRELOAD);
  assign out_hiz = (ir == OP_SAMPLEZ);

  always_ff @(posedge tck) begin
    if (state == S_CAP_DR) begin
      byp <= 1'b0;
      if (id_sel) id_sh <= ID_VALUE[ID_W-1:0];
    end else if (state == S_SH_DR) begin
      byp <= tdi;
      if (id_sel) id_sh <= {tdi, id_sh[ID_W-1:1]};
    end
  end

  assign bnd_capture = bnd_sel && (state == S_CAP_DR);
  assign bnd_shift   = bnd_sel && (state == S_SH_DR);
  assign bnd_update  = bnd_sel && (state == S_UPD_DR);

  assign dr_bit = bnd_sel ? bnd_tdo : (id_sel ? id_sh[0] : byp);

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (state == S_SH_IR) || (state == S_SH_DR);
      if (state == S_SH_IR)      tdo <= ir_sh[0];
      else if (state == S_SH_DR) tdo <= dr_bit;
    end

  assert_tlr_idcode_R1: assert property (@(posedge tck) disable iff (!trst_n)
    state == S_TLR |=> (ir == OP_IDCODE && !out_hiz));
  assert_ir_hold_R8: assert property (@(posedge tck) disable iff (!trst_n)
    !(state inside {S_TLR, S_UPD_IR}) |-> $stable(ir));
  assert_byp_cap_R6: assert property (@(posedge tck) disable iff (!trst_n)
    state == S_CAP_DR |=> byp == 1'b0);
  assert_hiz_bnd_R7: assert property (@(posedge tck) disable iff (!trst_n)
    out_hiz |-> bnd_sel);
  assert_strobe_one_R10: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({bnd_capture, bnd_shift, bnd_update}));
  assert_en_quiet_R9: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en |-> !bnd_capture && !bnd_update);
endmodule

// File: tb/mem_tap_tb_top.sv
`timescale 1ns/1ps
module mem_tap_tb_top;
  logic tck = 1'b0;
  logic tms = 1'b1, tdi = 1'b0, trst_n = 1'b0, bnd_tdo = 1'b1;
  logic tdo, tdo_en, bnd_sel, bnd_capture, bnd_shift, bnd_update, out_hiz;
  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  localparam logic [31:0] EXP_ID = {3'b000, 17'b01011001000100101, 11'b00000110100, 1'b1};
  localparam logic [7:0]  PAT    = 8'b0101_0110;
  // {opcode, expect bnd_sel, expect out_hiz}
  localparam logic [4:0] VEC [8] = '{
    {3'b000, 1'b1, 1'b0}, {3'b010, 1'b1, 1'b1}, {3'b100, 1'b1, 1'b0}, {3'b001, 1'b0, 1'b0},
    {3'b111, 1'b0, 1'b0}, {3'b010, 1'b1, 1'b1}, {3'b011, 1'b0, 1'b0}, {3'b101, 1'b0, 1'b0}
  };

  always #2 tck = ~tck;

  mem_tap dut_i (
    .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n), .bnd_tdo(bnd_tdo),
    .tdo(tdo), .tdo_en(tdo_en), .bnd_sel(bnd_sel), .bnd_capture(bnd_capture),
    .bnd_shift(bnd_shift), .bnd_update(bnd_update), .out_hiz(out_hiz)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    tms = m; tdi = d; o = tdo;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic load_ir(input logic [2:0] op);
    logic o;
    logic [2:0] cap;
    logic prev_hiz;
    prev_hiz = out_hiz;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    check("R9 tdo_en in Shift-IR", 32'(tdo_en), 32'd1);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, op[i], o);
      cap[i] = o;
    end
    check("R3 captured IR pattern", 32'(cap), 32'b001);
    check("R8 old instruction held in Exit1-IR", 32'(out_hiz), 32'(prev_hiz));
    step(1, 0, o); step(0, 0, o);
    check("R9 tdo_en low in Run-Test-Idle", 32'(tdo_en), 32'd0);
  endtask

  task automatic dr_scan(input int n, input logic [31:0] din, input logic exp_bnd,
                         output logic [31:0] dout);
    logic o;
    dout = '0;
    step(1, 0, o); step(0, 0, o);
    check("R10 bnd_capture in Capture-DR", 32'(bnd_capture), 32'(exp_bnd));
    step(0, 0, o);
    check("R10 bnd_shift in Shift-DR", 32'(bnd_shift), 32'(exp_bnd));
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o);
      dout[i] = o;
    end
    step(1, 0, o);
    check("R10 bnd_update in Update-DR", 32'(bnd_update), 32'(exp_bnd));
    step(0, 0, o);
  endtask

  initial begin
    logic o;
    logic [31:0] dout, exp;
    #9;
    @(negedge tck); #1;
    check("R2 tdo_en low during trst", 32'(tdo_en), 32'd0);
    trst_n = 1'b1;
    step(0, 0, o);
    check("R2 out_hiz low after reset", 32'(out_hiz), 32'd0);
    check("R2 IDCODE active (bnd_sel low)", 32'(bnd_sel), 32'd0);
    dr_scan(32, 32'hA5A5_0F0F, 1'b0, dout);
    check("R4 ID word after reset", dout, EXP_ID);

    for (int v = 0; v < 8; v++) begin
      load_ir(VEC[v][4:2]);
      check("R5 bnd_sel decode", 32'(bnd_sel), 32'(VEC[v][1]));
      check("R7 out_hiz decode", 32'(out_hiz), 32'(VEC[v][0]));
      dr_scan(8, 32'(PAT), VEC[v][1], dout);
      if (VEC[v][1])                exp = 32'hFF;
      else if (VEC[v][4:2] == 3'b001) exp = 32'(EXP_ID[7:0]);
      else                          exp = 32'({PAT[6:0], 1'b0});
      if (VEC[v][1]) check("R5 boundary path", dout, exp);
      else if (VEC[v][4:2] == 3'b001) check("R4 ID low byte", dout, exp);
      else check("R6 bypass path", dout, exp);
    end

    load_ir(3'b110);
    dr_scan(8, 32'(PAT), 1'b0, dout);
    check("R6 opcode 110 bypass", dout, 32'({PAT[6:0], 1'b0}));

    load_ir(3'b010);
    check("R7 out_hiz set", 32'(out_hiz), 32'd1);
    for (int k = 0; k < 5; k++) step(1, 0, o);
    check("R1 out_hiz released by TMS reset", 32'(out_hiz), 32'd0);
    step(0, 0, o);
    dr_scan(32, 32'h0, 1'b0, dout);
    check("R1 ID word after TMS reset", dout, EXP_ID);

    load_ir(3'b010);
    #0.5 trst_n = 1'b0;
    #0.5;
    check("R2 out_hiz released at once", 32'(out_hiz), 32'd0);
    check("R2 bnd_sel low at once", 32'(bnd_sel), 32'd0);
    @(negedge tck); #1;
    trst_n = 1'b1;
    step(0, 0, o);
    dr_scan(32, 32'h0, 1'b0, dout);
    check("R2 ID word after trst", dout, EXP_ID);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule